// File: doc/BRIEF.md
# Idle and Power-Down Clock Gating Controller

This block decides which clock domains of a small controller keep running. Software selects a low-power mode by writing two request bits: one for idle and one for power-down. In idle, only the CPU clock stops. The peripheral domain keeps running, and it covers the timers, the serial port, the interrupt logic and RAM. In power-down, the oscillator is told to stop, so every domain halts. RAM is flagged as being in retention and its contents are kept.

A new mode takes hold one clock edge after the edge that stores the request. This lets the writing instruction complete first. Idle ends when any unmasked interrupt line is high, and the idle bit clears as the CPU clock restarts. Power-down ignores every interrupt and ends only on a hardware reset. The reset asserts asynchronously and releases through a synchroniser.

Top module: `lpm_ctrl`

## Requirements
- R1: While reset is applied and after it, the block is in run mode: `cpu_clk_en_o`, `per_clk_en_o` and `osc_run_o` are 1, `ram_retain_o` is 0, and both request bits read 0.
- R2: A write with `req_idle_i`=1 and `req_pdown_i`=0 sets `idle_bit_o` at the edge that samples it. At the next edge `cpu_clk_en_o` falls, while `per_clk_en_o` and `osc_run_o` stay 1.
- R3: A write with `req_pdown_i`=1 sets `pdown_bit_o` at the sampling edge. At the next edge `cpu_clk_en_o`, `per_clk_en_o` and `osc_run_o` all fall and `ram_retain_o` rises.
- R4: When one write sets both request bits, the block enters power-down and not idle.
- R5: In idle, if any line has both `irq_i[k]` and `irq_en_i[k]` high at an edge, then after that edge `cpu_clk_en_o` is 1 and `idle_bit_o` is 0.
- R6: In idle, interrupt lines whose enable bit is 0 do not wake the CPU.
- R7: In power-down, no interrupt, enabled or not, changes any output. Only a hardware reset leaves it.
- R8: Driving `rst_ni` low forces the run-mode outputs of R1 at once, without waiting for a clock edge, and clears both request bits.
- R9: Request writes are accepted only in run mode. A write while in idle changes neither the request bits nor the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running oscillator clock that this block runs on |
| rst_ni | input | 1 | Hardware reset, active low; asserts asynchronously |
| req_wr_i | input | 1 | Strobe for a write to the mode request bits |
| req_idle_i | input | 1 | Idle request value to store |
| req_pdown_i | input | 1 | Power-down request value to store |
| irq_i | input | N_IRQ | Interrupt request lines |
| irq_en_i | input | N_IRQ | Per-line interrupt enables |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Enable for the peripheral and RAM clock domain |
| osc_run_o | output | 1 | Oscillator run enable |
| ram_retain_o | output | 1 | RAM is held in retention |
| idle_bit_o | output | 1 | Stored idle request bit |
| pdown_bit_o | output | 1 | Stored power-down request bit |

## Verification
If the mode state were wrong, the enable pattern would be wrong one edge after the request bits change. Examples are a CPU clock still running with the idle bit set, or a peripheral domain that has stopped while the oscillator still runs. A wake-up path that is stuck or missing its mask shows up on the edge that samples the interrupt. Either `cpu_clk_en_o` fails to return, or it returns for a masked line. A leak out of power-down shows as `osc_run_o` rising without a reset. A reset that does not act asynchronously leaves the enables low after `rst_ni` falls, before any edge.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_PDOWN = 2'd2
  } lpm_mode_e;

  typedef struct packed {
    logic cpu;
    logic per;
    logic osc;
    logic retain;
  } lpm_gate_t;

endpackage

// File: rtl/lpm_rst_sync.sv
module lpm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] shift_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) shift_q <= 1'b0;
        else         shift_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) shift_q <= '0;
        else         shift_q <= {shift_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_no = shift_q[STAGES-1];

endmodule

// File: rtl/lpm_wake.sv
module lpm_wake #(
  parameter int unsigned N_IRQ = 5
) (
  input  logic [N_IRQ-1:0] irq_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  output logic             wake_o
);

  logic [N_IRQ-1:0] masked;

  // one gate per interrupt line; any unmasked request wakes the CPU
  for (genvar k = 0; k < N_IRQ; k++) begin : g_line
    assign masked[k] = irq_i[k] & irq_en_i[k];
  end

  assign wake_o = |masked;

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_i,
  input  logic      idle_req_i,
  input  logic      pdown_req_i,
  input  logic      wake_i,
  output lpm_mode_e mode_o,
  output logic      idle_bit_o,
  output logic      pdown_bit_o
);

  lpm_mode_e mode_q, mode_d;
  logic      idle_q, idle_d;
  logic      pdn_q,  pdn_d;

  always_comb begin
    mode_d = mode_q;
    idle_d = idle_q;
    pdn_d  = pdn_q;
    unique case (mode_q)
      MODE_RUN: begin
        // stored bits take effect one edge after the write
        if (pdn_q)       mode_d = MODE_PDOWN;
        else if (idle_q) mode_d = MODE_IDLE;
        if (wr_i) begin
          idle_d = idle_req_i;
          pdn_d  = pdown_req_i;
        end
      end
      MODE_IDLE: begin
        if (wake_i) begin
          mode_d = MODE_RUN;
          idle_d = 1'b0;
        end
      end
      MODE_PDOWN: begin
        mode_d = MODE_PDOWN;
      end
      default: begin
        mode_d = MODE_RUN;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RUN;
      idle_q <= 1'b0;
      pdn_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      idle_q <= idle_d;
      pdn_q  <= pdn_d;
    end
  end

  assign mode_o      = mode_q;
  assign idle_bit_o  = idle_q;
  assign pdown_bit_o = pdn_q;

endmodule

// File: rtl/lpm_gate.sv
module lpm_gate
  import lpm_pkg::*;
(
  input  lpm_mode_e mode_i,
  output lpm_gate_t gate_o
);

  always_comb begin
    unique case (mode_i)
      MODE_IDLE:  gate_o = '{cpu: 1'b0, per: 1'b1, osc: 1'b1, retain: 1'b0};
      MODE_PDOWN: gate_o = '{cpu: 1'b0, per: 1'b0, osc: 1'b0, retain: 1'b1};
      default:    gate_o = '{cpu: 1'b1, per: 1'b1, osc: 1'b1, retain: 1'b0};
    endcase
  end

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned N_IRQ       = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_wr_i,
  input  logic             req_idle_i,
  input  logic             req_pdown_i,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  output logic             cpu_clk_en_o,
  output logic             per_clk_en_o,
  output logic             osc_run_o,
  output logic             ram_retain_o,
  output logic             idle_bit_o,
  output logic             pdown_bit_o
);

  logic      rst_sync_n;
  logic      wake;
  lpm_mode_e mode;
  lpm_gate_t gate;

  lpm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  lpm_wake #(.N_IRQ(N_IRQ)) u_wake (
    .irq_i    (irq_i),
    .irq_en_i (irq_en_i),
    .wake_o   (wake)
  );

  lpm_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .wr_i        (req_wr_i),
    .idle_req_i  (req_idle_i),
    .pdown_req_i (req_pdown_i),
    .wake_i      (wake),
    .mode_o      (mode),
    .idle_bit_o  (idle_bit_o),
    .pdown_bit_o (pdown_bit_o)
  );

  lpm_gate u_gate (
    .mode_i (mode),
    .gate_o (gate)
  );

  assign cpu_clk_en_o = gate.cpu;
  assign per_clk_en_o = gate.per;
  assign osc_run_o    = gate.osc;
  assign ram_retain_o = gate.retain;

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
  parameter int unsigned N_IRQ = 5
) (
  input logic             clk_i,
  input logic             rst_sync_n,
  input logic [N_IRQ-1:0] irq_i,
  input logic [N_IRQ-1:0] irq_en_i,
  input logic             cpu_clk_en_o,
  input logic             per_clk_en_o,
  input logic             osc_run_o,
  input logic             ram_retain_o,
  input logic             idle_bit_o,
  input logic             pdown_bit_o
);

  logic in_idle;
  assign in_idle = !cpu_clk_en_o && per_clk_en_o;

  assert_idle_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (cpu_clk_en_o && idle_bit_o && !pdown_bit_o) |=> (!cpu_clk_en_o && per_clk_en_o && osc_run_o));

  // covers R4 as well: the power-down bit wins whatever the idle bit holds
  assert_pdown_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (cpu_clk_en_o && pdown_bit_o) |=> (!cpu_clk_en_o && !per_clk_en_o && !osc_run_o && ram_retain_o));

  assert_idle_wake_R5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (in_idle && |(irq_i & irq_en_i)) |=> (cpu_clk_en_o && !idle_bit_o));

  assert_masked_irq_R6: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (in_idle && !(|(irq_i & irq_en_i))) |=> !cpu_clk_en_o);

  assert_pdown_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !osc_run_o |=> (!osc_run_o && ram_retain_o));

  assert_no_write_asleep_R9: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !cpu_clk_en_o |=> $stable(pdown_bit_o));

  // R3: domains stop in order; the peripheral domain never runs without the oscillator
  always_comb begin
    if (rst_sync_n) begin
      assert_domain_order_R3: assert (!(per_clk_en_o && !osc_run_o) && !(cpu_clk_en_o && !per_clk_en_o));
    end
  end

endmodule

bind lpm_ctrl lpm_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk_i        (clk_i),
  .rst_sync_n   (rst_sync_n),
  .irq_i        (irq_i),
  .irq_en_i     (irq_en_i),
  .cpu_clk_en_o (cpu_clk_en_o),
  .per_clk_en_o (per_clk_en_o),
  .osc_run_o    (osc_run_o),
  .ram_retain_o (ram_retain_o),
  .idle_bit_o   (idle_bit_o),
  .pdown_bit_o  (pdown_bit_o)
);

// File: tb/test_lpm_ctrl.sv
`timescale 1ns/1ps
module test_lpm_ctrl;

  localparam int N_IRQ = 5;
  // expected pattern {cpu, per, osc, retain, idle_bit, pdown_bit}
  localparam logic [5:0] E_RUN   = 6'b111000;
  localparam logic [5:0] E_RUNI  = 6'b111010;
  localparam logic [5:0] E_RUNP  = 6'b111001;
  localparam logic [5:0] E_RUNB  = 6'b111011;
  localparam logic [5:0] E_IDLE  = 6'b011010;
  localparam logic [5:0] E_PD    = 6'b000101;
  localparam logic [5:0] E_PDB   = 6'b000111;

  typedef struct {
    string      tag;
    logic [5:0] val;
  } exp_t;

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic             req_wr_i, req_idle_i, req_pdown_i;
  logic [N_IRQ-1:0] irq_i, irq_en_i;
  logic             cpu_clk_en_o, per_clk_en_o, osc_run_o, ram_retain_o;
  logic             idle_bit_o, pdown_bit_o;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  always #2.5 clk_i = ~clk_i;

  lpm_ctrl #(.N_IRQ(N_IRQ), .SYNC_STAGES(2)) i_lpm_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_wr_i     (req_wr_i),
    .req_idle_i   (req_idle_i),
    .req_pdown_i  (req_pdown_i),
    .irq_i        (irq_i),
    .irq_en_i     (irq_en_i),
    .cpu_clk_en_o (cpu_clk_en_o),
    .per_clk_en_o (per_clk_en_o),
    .osc_run_o    (osc_run_o),
    .ram_retain_o (ram_retain_o),
    .idle_bit_o   (idle_bit_o),
    .pdown_bit_o  (pdown_bit_o)
  );

  function automatic logic [5:0] observed();
    return {cpu_clk_en_o, per_clk_en_o, osc_run_o, ram_retain_o, idle_bit_o, pdown_bit_o};
  endfunction

  task automatic compare(string tag, logic [5:0] expv);
    logic [5:0] got;
    got = observed();
    n_cmp++;
    if (got !== expv) begin
      n_bad++;
      $display("FAIL %s got %b expected %b at %0t", tag, got, expv, $time);
    end
  endtask

  // driver: apply inputs at the falling edge, queue what the next rising edge must produce
  task automatic cyc(string tag, logic wr, logic idl, logic pd,
                     logic [N_IRQ-1:0] irq, logic [N_IRQ-1:0] en, logic [5:0] expv);
    exp_t e;
    @(negedge clk_i);
    req_wr_i    = wr;
    req_idle_i  = idl;
    req_pdown_i = pd;
    irq_i       = irq;
    irq_en_i    = en;
    e.tag = tag;
    e.val = expv;
    exp_q.push_back(e);
  endtask

  // monitor: compare shortly after each rising edge
  always @(posedge clk_i) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      compare(e.tag, e.val);
    end
  end

  task automatic hw_reset(string tag);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #0.5;
    compare(tag, E_RUN);
    cyc(tag, 0, 0, 0, '0, '0, E_RUN);
    cyc(tag, 0, 0, 0, '0, '0, E_RUN);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < 4; i++) cyc(tag, 0, 0, 0, '0, '0, E_RUN);
  endtask

  initial begin
    rst_ni = 1'b0; req_wr_i = 0; req_idle_i = 0; req_pdown_i = 0;
    irq_i = '0; irq_en_i = '0;
    // R1: outputs during and after reset
    cyc("R1 in reset", 0, 0, 0, '0, '0, E_RUN);
    cyc("R1 in reset", 0, 0, 0, '0, '0, E_RUN);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < 4; i++) cyc("R1 after reset", 0, 0, 0, '0, '0, E_RUN);

    // R2: idle entry one edge after the request is stored
    cyc("R2 bit set", 1, 1, 0, '0, '0, E_RUNI);
    cyc("R2 idle", 0, 0, 0, '0, '0, E_IDLE);
    cyc("R2 idle held", 0, 0, 0, '0, '0, E_IDLE);
    // R6: masked line does not wake
    cyc("R6 masked", 0, 0, 0, 5'b00010, 5'b00001, E_IDLE);
    cyc("R6 masked", 0, 0, 0, 5'b11110, 5'b00001, E_IDLE);
    // R9: write while idle ignored
    cyc("R9 write asleep", 1, 0, 1, '0, 5'b11111, E_IDLE);
    cyc("R9 still idle", 0, 0, 0, '0, 5'b11111, E_IDLE);
    // R5: unmasked line wakes and clears the idle bit
    cyc("R5 wake", 0, 0, 0, 5'b10010, 5'b00010, E_RUN);
    cyc("R5 running", 0, 0, 0, '0, '0, E_RUN);

    // R3: power-down entry
    cyc("R3 bit set", 1, 0, 1, '0, '0, E_RUNP);
    cyc("R3 power-down", 0, 0, 0, '0, '0, E_PD);
    // R7: interrupts cannot leave power-down
    for (int i = 0; i < 3; i++) cyc("R7 irq ignored", 0, 0, 0, 5'b11111, 5'b11111, E_PD);
    cyc("R7 write ignored", 1, 1, 0, '0, '0, E_PD);
    // R8: asynchronous hardware reset leaves power-down
    hw_reset("R8 reset from power-down");

    // R4: both bits in one write -> power-down
    cyc("R4 both set", 1, 1, 1, '0, '0, E_RUNB);
    cyc("R4 power-down wins", 0, 0, 0, 5'b00001, 5'b00001, E_PDB);
    cyc("R4 held", 0, 0, 0, 5'b00001, 5'b00001, E_PDB);
    hw_reset("R8 reset clears bits");

    // R8: reset from idle too
    cyc("R2 second entry", 1, 1, 0, '0, '0, E_RUNI);
    cyc("R2 second idle", 0, 0, 0, '0, '0, E_IDLE);
    hw_reset("R8 reset from idle");

    @(negedge clk_i);
    @(negedge clk_i);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule